// File: doc/BRIEF.md
# DC Bus Brake and Fault Supervisor

This block watches the DC link of a motor drive and decides two things every clock cycle: whether the braking resistor switch must conduct, and whether the power stage may run. Bus voltage, the magnitude of each phase current and the board temperature arrive as scaled digital samples. Bus voltage is in 10 mV steps, current in 10 mA steps and temperature in 0.01 °C steps. Several discrete fault lines arrive as well.

The brake uses two programmable thresholds with hysteresis between them. A fixed protection level above them forces the brake on whatever the programmed values are. Fault causes are captured in a latched fault register. Only a host-requested clear, through a flag that the block clears itself, empties that register. A mask register can keep the undervoltage fault away from the fault output. A small status register reports current limiting, the live brake state and a sticky record that the brake has fired. A flat register port gives the host access to the thresholds and the registers.

Top module: `bvs_top`

## Requirements
- R1: After reset the registers read: address 0 (brake-on threshold) 36000, 1 (brake-off threshold) 34000, 2 (undervoltage) 3500, 3 (programmable overvoltage) 38500, 4 (full-scale current) 3000, 5 (fault) 0, 6 (fault mask) 0xFFFF, 7 (status) 0, 8 (control) 0. The brake output is low after reset.
- R2: The brake output rises one cycle after the bus sample is strictly above the brake-on threshold. It falls one cycle after the sample is strictly below the brake-off threshold. Between the two it holds its value.
- R3: A bus sample strictly above 38500 turns the brake on in the next cycle, whatever the programmed thresholds are.
- R4: A write to address 0 takes effect only if the value is strictly greater than the current brake-off threshold. A write to address 1 takes effect only if the value is strictly less than the current brake-on threshold. A rejected write leaves the old value in place.
- R5: Each cycle the fault register ORs in these causes:
  - bit 0: watchdog input
  - bit 1: enable input low
  - bit 2: temperature above 8500
  - bit 4: high-side overcurrent input
  - bits 5, 6, 7: phase U, V, W overcurrent
  - bit 8: bus below the undervoltage threshold
  - bit 9: bus above the programmable overvoltage threshold
  - bit 10: bus above 40000
  - bit 11: module fault input
  - bit 14: serial overrun input
  - bit 15: serial framing input

  Bits 3, 12 and 13 read 0. A set bit stays set until a clear.
- R6: A phase overcurrent fault is raised when 4·current > 5·fullscale, computed without overflow over the whole 16-bit range of both values.
- R7: Writes to the fault register (address 5) have no effect.
- R8: Writing 1 to bit 0 of address 8 sets the clear flag. In the next cycle the block empties the fault register and drops the flag. A cause still present sets its bit again one cycle later.
- R9: Only bit 8 of the fault mask is writable; the other bits read 1. A zero in bit 8 keeps the undervoltage fault away from the fault output and the drive enable.
- R10: The fault output is high exactly when no unmasked fault bit is set. The drive enable is the fault output ANDed with the live enable input.
- R11: Status bit 0 is the current-limit input registered. Bit 1 is the brake state. Bit 2 is set one cycle after the brake state is high, and it stays set until a write to address 7 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_v | input | 16 | Bus voltage sample, 10 mV units |
| cur_u | input | 16 | Phase U current magnitude, 10 mA units |
| cur_v | input | 16 | Phase V current magnitude, 10 mA units |
| cur_w | input | 16 | Phase W current magnitude, 10 mA units |
| temp_c | input | 16 | Board temperature, 0.01 °C units |
| wdog_to | input | 1 | Communication watchdog expired |
| enable_in | input | 1 | External enable, high to allow driving |
| hs_ocp | input | 1 | High-side overcurrent detector |
| module_flt | input | 1 | Power module temperature or gate supply fault |
| ser_ovr | input | 1 | Serial receiver overrun |
| ser_frm | input | 1 | Serial receiver framing error |
| ilim_in | input | 1 | Current loop is limiting |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on address |
| brake_on | output | 1 | Brake resistor switch |
| fault_out | output | 1 | High in normal operation, low on unmasked fault |
| drive_en | output | 1 | Power stage allowed to switch |

## Verification
The bench targets the edges of every comparison. It drives a bus exactly at the brake-on level, which must not trip the brake, and a sample just past 38500 with the programmed thresholds set higher still; a design that used >= or ignored the fixed level would brake at the wrong voltage. It sets both the full-scale and the phase currents to 0xFFFF, and a 16-bit product would wrap and raise a false overcurrent. It also puts current on the exact 125 % point and one step above it. It requests a clear while the enable input stays low, and checks for the one-cycle empty register followed by re-latching; a design that gated the clear on the cause would never clear, and one that kept the flag would clear forever. Rejected threshold writes, ignored fault writes and a sticky clear while the brake is off are read back through the register port.

// File: rtl/bvs_pkg.sv
`timescale 1ns/1ps
// Shared constants for the bus brake and fault supervisor: fault bit
// positions, register addresses and the maskable-bit pattern.
package bvs_pkg;
    localparam int FLT_W     = 16;
    localparam int FB_WDOG   = 0;
    localparam int FB_NOEN   = 1;
    localparam int FB_OTEMP  = 2;
    localparam int FB_HSOC   = 4;
    localparam int FB_PH0    = 5;   // phases occupy FB_PH0 .. FB_PH0+2
    localparam int FB_UV     = 8;
    localparam int FB_OV     = 9;
    localparam int FB_OVMAX  = 10;
    localparam int FB_MOD    = 11;
    localparam int FB_OVR    = 14;
    localparam int FB_FRM    = 15;
    localparam logic [FLT_W-1:0] MASKABLE = 16'h0100;

    typedef enum logic [3:0] {
        A_BRK_HI = 4'd0,
        A_BRK_LO = 4'd1,
        A_UNDERV = 4'd2,
        A_OVERV  = 4'd3,
        A_FSCALE = 4'd4,
        A_FAULT  = 4'd5,
        A_FMASK  = 4'd6,
        A_STATUS = 4'd7,
        A_CTRL   = 4'd8
    } reg_addr_e;
endpackage

// File: rtl/bvs_brake.sv
`timescale 1ns/1ps
// Brake switch with hysteresis. On above on_th, off below off_th, hold
// between them; a fixed HARD_ON level forces it on regardless.
// Assumes the register file keeps on_th > off_th.
module bvs_brake #(
    parameter int           W       = 16,
    parameter logic [W-1:0] HARD_ON = 16'd38500
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bus_v,
    input  logic [W-1:0] on_th,
    input  logic [W-1:0] off_th,
    output logic         brake_q
);
    // Purpose: next brake state from the bus sample, fixed level first.
    always_ff @(posedge clk) begin
        if (!rst_n)                brake_q <= 1'b0;
        else if (bus_v > HARD_ON)  brake_q <= 1'b1;
        else if (bus_v > on_th)    brake_q <= 1'b1;
        else if (bus_v < off_th)   brake_q <= 1'b0;
    end

    assert_hard_brake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_v > HARD_ON) |=> brake_q);
    assert_brake_engage_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_v > on_th) |=> brake_q);
    assert_brake_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_v < off_th && bus_v <= HARD_ON) |=> !brake_q);
endmodule

// File: rtl/bvs_fault_cause.sv
`timescale 1ns/1ps
// Combinational fault-cause vector. It compares the samples against the
// thresholds and maps the discrete inputs onto their fault bit positions.
// Phase overcurrent uses 4*I > 5*FS in W+3 bits, so neither side overflows.
module bvs_fault_cause
    import bvs_pkg::*;
#(
    parameter int           W        = 16,
    parameter int           NPH      = 3,
    parameter logic [W-1:0] TEMP_LIM = 16'd8500,
    parameter logic [W-1:0] OV_MAX   = 16'd40000
) (
    input  logic [W-1:0]       bus_v,
    input  logic [NPH*W-1:0]   cur_flat,
    input  logic [W-1:0]       temp_c,
    input  logic [W-1:0]       uv_th,
    input  logic [W-1:0]       ov_th,
    input  logic [W-1:0]       fscale,
    input  logic               wdog_to,
    input  logic               enable_in,
    input  logic               hs_ocp,
    input  logic               module_flt,
    input  logic               ser_ovr,
    input  logic               ser_frm,
    output logic [FLT_W-1:0]   cause
);
    localparam int XW = W + 3;

    logic [XW-1:0]  fs_x5;
    logic [NPH-1:0] ph_oc;

    // Purpose: five times full scale, shared by every phase comparator.
    always_comb fs_x5 = ({3'b000, fscale} << 2) + {3'b000, fscale};

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        logic [XW-1:0] cur_x4;
        // Purpose: four times this phase's current, compared to 5*FS.
        always_comb begin
            cur_x4   = {1'b0, cur_flat[p*W +: W], 2'b00};
            ph_oc[p] = (cur_x4 > fs_x5);
        end
    end

    // Purpose: place each cause at its fault register bit.
    always_comb begin
        cause                         = '0;
        cause[FB_WDOG]                = wdog_to;
        cause[FB_NOEN]                = !enable_in;
        cause[FB_OTEMP]               = (temp_c > TEMP_LIM);
        cause[FB_HSOC]                = hs_ocp;
        cause[FB_PH0 +: NPH]          = ph_oc;
        cause[FB_UV]                  = (bus_v < uv_th);
        cause[FB_OV]                  = (bus_v > ov_th);
        cause[FB_OVMAX]               = (bus_v > OV_MAX);
        cause[FB_MOD]                 = module_flt;
        cause[FB_OVR]                 = ser_ovr;
        cause[FB_FRM]                 = ser_frm;
    end
endmodule

// File: rtl/bvs_fault_reg.sv
`timescale 1ns/1ps
// Latched fault register with a self-clearing clear flag. A request sets
// the flag; in the flagged cycle the register empties and the flag drops.
// Causes still present latch again in the following cycle.
module bvs_fault_reg #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cause,
    input  logic         clr_req,
    output logic [N-1:0] fault_q,
    output logic         clr_q
);
    // Purpose: accumulate causes, or empty once when the clear flag is up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= '0;
            clr_q   <= 1'b0;
        end else if (clr_q) begin
            fault_q <= '0;
            clr_q   <= 1'b0;
        end else begin
            fault_q <= fault_q | cause;
            clr_q   <= clr_req;
        end
    end

    assert_clear_selfclears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |=> (!clr_q && fault_q == '0));
    assert_fault_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_q |=> ((fault_q & $past(fault_q)) == $past(fault_q)));
endmodule

// File: rtl/bvs_status.sv
`timescale 1ns/1ps
// Status register: registered current-limit flag, live brake state and a
// sticky brake-was-on bit. A status write clears the sticky bit, but a
// brake that is still on sets it again at once.
module bvs_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       brake_q,
    input  logic       ilim_in,
    input  logic       clr_sticky,
    output logic [2:0] stat
);
    logic ilim_q;
    logic sticky_q;

    // Purpose: register the limit flag and update the sticky brake record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ilim_q   <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            ilim_q   <= ilim_in;
            sticky_q <= (clr_sticky ? 1'b0 : sticky_q) | brake_q;
        end
    end

    // Purpose: assemble the status word.
    always_comb stat = {sticky_q, brake_q, ilim_q};

    assert_sticky_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        brake_q |=> sticky_q);
    assert_sticky_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q && !clr_sticky) |=> sticky_q);
endmodule

// File: rtl/bvs_top.sv
`timescale 1ns/1ps
// Bus brake and fault supervisor top. It holds the programmable thresholds
// and the mask, decodes the register port, and derives the fault output
// and the drive enable. Register reads are combinational on the address.
module bvs_top
    import bvs_pkg::*;
#(
    parameter int           W         = 16,
    parameter logic [W-1:0] DEF_ON    = 16'd36000,
    parameter logic [W-1:0] DEF_OFF   = 16'd34000,
    parameter logic [W-1:0] DEF_UV    = 16'd3500,
    parameter logic [W-1:0] DEF_OV    = 16'd38500,
    parameter logic [W-1:0] DEF_FS    = 16'd3000,
    parameter logic [W-1:0] HARD_ON   = 16'd38500,
    parameter logic [W-1:0] OV_MAX    = 16'd40000,
    parameter logic [W-1:0] TEMP_LIM  = 16'd8500
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bus_v,
    input  logic [W-1:0] cur_u,
    input  logic [W-1:0] cur_v,
    input  logic [W-1:0] cur_w,
    input  logic [W-1:0] temp_c,
    input  logic         wdog_to,
    input  logic         enable_in,
    input  logic         hs_ocp,
    input  logic         module_flt,
    input  logic         ser_ovr,
    input  logic         ser_frm,
    input  logic         ilim_in,
    input  logic         reg_wr,
    input  logic [3:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    output logic         brake_on,
    output logic         fault_out,
    output logic         drive_en
);
    localparam int NPH = 3;

    logic [W-1:0]     on_q, off_q, uv_q, ov_q, fs_q;
    logic [FLT_W-1:0] mask_q;
    logic [FLT_W-1:0] cause, fault_q;
    logic             clr_q, brake_q;
    logic [2:0]       stat;
    logic             wr_ctrl, wr_stat;

    // Purpose: write strobes for the side-effect registers.
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == A_CTRL) && reg_wdata[0];
        wr_stat = reg_wr && (reg_addr == A_STATUS);
    end

    // Purpose: threshold and mask registers, with brake order protection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q   <= DEF_ON;
            off_q  <= DEF_OFF;
            uv_q   <= DEF_UV;
            ov_q   <= DEF_OV;
            fs_q   <= DEF_FS;
            mask_q <= '1;
        end else if (reg_wr) begin
            case (reg_addr)
                A_BRK_HI: if (reg_wdata > off_q) on_q  <= reg_wdata;
                A_BRK_LO: if (reg_wdata < on_q)  off_q <= reg_wdata;
                A_UNDERV: uv_q <= reg_wdata;
                A_OVERV:  ov_q <= reg_wdata;
                A_FSCALE: fs_q <= reg_wdata;
                A_FMASK:  mask_q <= ~MASKABLE | (reg_wdata & MASKABLE);
                default:  ;
            endcase
        end
    end

    bvs_brake #(.W(W), .HARD_ON(HARD_ON)) u_brake (
        .clk(clk), .rst_n(rst_n), .bus_v(bus_v),
        .on_th(on_q), .off_th(off_q), .brake_q(brake_q)
    );

    bvs_fault_cause #(.W(W), .NPH(NPH), .TEMP_LIM(TEMP_LIM), .OV_MAX(OV_MAX)) u_cause (
        .bus_v(bus_v), .cur_flat({cur_w, cur_v, cur_u}), .temp_c(temp_c),
        .uv_th(uv_q), .ov_th(ov_q), .fscale(fs_q),
        .wdog_to(wdog_to), .enable_in(enable_in), .hs_ocp(hs_ocp),
        .module_flt(module_flt), .ser_ovr(ser_ovr), .ser_frm(ser_frm),
        .cause(cause)
    );

    bvs_fault_reg #(.N(FLT_W)) u_freg (
        .clk(clk), .rst_n(rst_n), .cause(cause), .clr_req(wr_ctrl),
        .fault_q(fault_q), .clr_q(clr_q)
    );

    bvs_status u_stat (
        .clk(clk), .rst_n(rst_n), .brake_q(brake_q), .ilim_in(ilim_in),
        .clr_sticky(wr_stat), .stat(stat)
    );

    // Purpose: outward fault and drive signals from the masked register.
    always_comb begin
        brake_on  = brake_q;
        fault_out = ~|(fault_q & mask_q);
        drive_en  = fault_out & enable_in;
    end

    // Purpose: register read multiplexer.
    always_comb begin
        case (reg_addr)
            A_BRK_HI: reg_rdata = on_q;
            A_BRK_LO: reg_rdata = off_q;
            A_UNDERV: reg_rdata = uv_q;
            A_OVERV:  reg_rdata = ov_q;
            A_FSCALE: reg_rdata = fs_q;
            A_FAULT:  reg_rdata = fault_q;
            A_FMASK:  reg_rdata = mask_q;
            A_STATUS: reg_rdata = {{(W-3){1'b0}}, stat};
            A_CTRL:   reg_rdata = {{(W-1){1'b0}}, clr_q};
            default:  reg_rdata = '0;
        endcase
    end

    assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        on_q > off_q);
    assert_unmaskable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(fault_q & ~MASKABLE)) |-> !fault_out);
    assert_enable_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_in |-> !drive_en);
    assert_mask_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> ($countones(mask_q) >= FLT_W - 1));
endmodule

// File: tb/bvs_top_tb.sv
`timescale 1ns/1ps
module bvs_top_tb;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [15:0] bus_v = 16'd30000, cur_u = 16'd1000, cur_v = 16'd1000, cur_w = 16'd1000;
    logic [15:0] temp_c = 16'd2500;
    logic        wdog_to = 0, enable_in = 1, hs_ocp = 0, module_flt = 0;
    logic        ser_ovr = 0, ser_frm = 0, ilim_in = 0;
    logic        reg_wr = 0;
    logic [3:0]  reg_addr = 4'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        brake_on, fault_out, drive_en;

    bvs_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_v(bus_v), .cur_u(cur_u), .cur_v(cur_v),
        .cur_w(cur_w), .temp_c(temp_c), .wdog_to(wdog_to), .enable_in(enable_in),
        .hs_ocp(hs_ocp), .module_flt(module_flt), .ser_ovr(ser_ovr), .ser_frm(ser_frm),
        .ilim_in(ilim_in), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .brake_on(brake_on), .fault_out(fault_out),
        .drive_en(drive_en)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Model state, built from the requirements.
    logic [15:0] m_hi, m_lo, m_uv, m_ov, m_fs, m_fault;
    logic        m_mask8, m_clr, m_brake, m_sticky, m_ilim;

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic ph_oc(logic [15:0] c, logic [15:0] fs);
        return ({3'b0, c} * 19'd4) > ({3'b0, fs} * 19'd5);
    endfunction

    function automatic logic [15:0] m_cause();
        logic [15:0] c = '0;
        c[0]  = wdog_to;
        c[1]  = !enable_in;
        c[2]  = temp_c > 16'd8500;
        c[4]  = hs_ocp;
        c[5]  = ph_oc(cur_u, m_fs);
        c[6]  = ph_oc(cur_v, m_fs);
        c[7]  = ph_oc(cur_w, m_fs);
        c[8]  = bus_v < m_uv;
        c[9]  = bus_v > m_ov;
        c[10] = bus_v > 16'd40000;
        c[11] = module_flt;
        c[14] = ser_ovr;
        c[15] = ser_frm;
        return c;
    endfunction

    function automatic logic [15:0] m_mask();
        return 16'hFEFF | {7'b0, m_mask8, 8'b0};
    endfunction

    function automatic logic [15:0] m_reg(logic [3:0] a);
        case (a)
            4'd0: return m_hi;
            4'd1: return m_lo;
            4'd2: return m_uv;
            4'd3: return m_ov;
            4'd4: return m_fs;
            4'd5: return m_fault;
            4'd6: return m_mask();
            4'd7: return {13'b0, m_sticky, m_brake, m_ilim};
            4'd8: return {15'b0, m_clr};
            default: return 16'h0;
        endcase
    endfunction

    task automatic cycle();
        logic [15:0] nf;
        logic        nc, nb, ns;
        @(posedge clk);
        if (!rst_n) begin
            m_hi = 16'd36000; m_lo = 16'd34000; m_uv = 16'd3500; m_ov = 16'd38500;
            m_fs = 16'd3000; m_mask8 = 1; m_fault = 0; m_clr = 0; m_brake = 0;
            m_sticky = 0; m_ilim = 0;
        end else begin
            nf = m_clr ? 16'h0 : (m_fault | m_cause());
            nc = m_clr ? 1'b0 : (reg_wr && reg_addr == 4'd8 && reg_wdata[0]);
            if (bus_v > 16'd38500 || bus_v > m_hi) nb = 1;
            else if (bus_v < m_lo) nb = 0;
            else nb = m_brake;
            ns = ((reg_wr && reg_addr == 4'd7) ? 1'b0 : m_sticky) | m_brake;
            if (reg_wr) begin
                case (reg_addr)
                    4'd0: if (reg_wdata > m_lo) m_hi = reg_wdata;
                    4'd1: if (reg_wdata < m_hi) m_lo = reg_wdata;
                    4'd2: m_uv = reg_wdata;
                    4'd3: m_ov = reg_wdata;
                    4'd4: m_fs = reg_wdata;
                    4'd6: m_mask8 = reg_wdata[8];
                    default: ;
                endcase
            end
            m_ilim = ilim_in; m_fault = nf; m_clr = nc; m_brake = nb; m_sticky = ns;
        end
        @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        cycle();
        reg_wr = 0;
    endtask

    task automatic rd_chk(string tag, logic [3:0] a);
        reg_addr = a;
        #0.2;
        chk(tag, $sformatf("reg%0d", a), reg_rdata, m_reg(a));
    endtask

    task automatic chk_all(string tag);
        logic fo;
        fo = ~|(m_fault & m_mask());
        chk(tag, "brake_on", {15'b0, brake_on}, {15'b0, m_brake});
        chk(tag, "fault_out", {15'b0, fault_out}, {15'b0, fo});
        chk(tag, "drive_en", {15'b0, drive_en}, {15'b0, fo & enable_in});
        rd_chk(tag, 4'd5);
        rd_chk(tag, 4'd7);
        rd_chk(tag, 4'd8);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        @(negedge clk);
        for (int i = 0; i < 3; i++) cycle();
        rst_n = 1;

        // R1: reset values
        chk("R1", "brake_on", {15'b0, brake_on}, 16'd0);
        for (int a = 0; a < 9; a++) begin
            reg_addr = a[3:0];
            #0.2;
            chk("R1", $sformatf("reg%0d", a), reg_rdata, m_reg(a[3:0]));
        end
        chk("R1", "mask", m_reg(4'd6), 16'hFFFF);

        // R2: hysteresis, equal to on level does not trip
        bus_v = 16'd36000; cycle(); chk("R2", "at on", {15'b0, brake_on}, 16'd0);
        bus_v = 16'd36001; cycle(); chk("R2", "above on", {15'b0, brake_on}, 16'd1);
        bus_v = 16'd34000; cycle(); chk("R2", "at off", {15'b0, brake_on}, 16'd1);
        bus_v = 16'd33999; cycle(); chk("R2", "below off", {15'b0, brake_on}, 16'd0);
        chk_all("R2");

        // R11: sticky stays until status write
        rd_chk("R11", 4'd7);
        chk("R11", "sticky", m_reg(4'd7) & 16'h4, 16'h4);
        wr(4'd7, 16'h0); rd_chk("R11", 4'd7);
        reg_addr = 4'd7; #0.2; chk("R11", "cleared", reg_rdata, 16'h0);
        ilim_in = 1; cycle(); rd_chk("R11", 4'd7); ilim_in = 0;

        // R3 and R4: raise thresholds, fixed level still brakes
        wr(4'd0, 16'd39500); wr(4'd1, 16'd39000);
        wr(4'd0, 16'd38000); wr(4'd1, 16'd39500);
        reg_addr = 4'd0; #0.2; chk("R4", "on kept", reg_rdata, 16'd39500);
        reg_addr = 4'd1; #0.2; chk("R4", "off kept", reg_rdata, 16'd39000);
        bus_v = 16'd38500; cycle(); chk("R3", "at hard", {15'b0, brake_on}, 16'd0);
        bus_v = 16'd38501; cycle(); chk("R3", "above hard", {15'b0, brake_on}, 16'd1);
        chk_all("R3");
        bus_v = 16'd30000; cycle(); cycle();
        wr(4'd1, 16'd34000); wr(4'd0, 16'd36000);
        wr(4'd8, 16'd1); cycle(); cycle(); cycle();
        chk_all("R8");

        // R6: no overflow at full range, exact 125 % point
        wr(4'd4, 16'hFFFF);
        cur_u = 16'hFFFF; cur_v = 16'hFFFF; cur_w = 16'hFFFF; cycle();
        reg_addr = 4'd5; #0.2; chk("R6", "max range", reg_rdata & 16'h00E0, 16'h0);
        wr(4'd4, 16'd100); cur_u = 16'd125; cur_v = 16'd125; cur_w = 16'd125; cycle();
        reg_addr = 4'd5; #0.2; chk("R6", "at 125%", reg_rdata & 16'h00E0, 16'h0);
        cur_u = 16'd126; cycle();
        reg_addr = 4'd5; #0.2; chk("R6", "above", reg_rdata, 16'h0020);
        chk("R10", "fault_out", {15'b0, fault_out}, 16'd0);

        // R7: fault write ignored
        wr(4'd5, 16'h0000);
        reg_addr = 4'd5; #0.2; chk("R7", "fault kept", reg_rdata, 16'h0020);
        cur_u = 16'd1000; cur_v = 16'd1000; cur_w = 16'd1000; wr(4'd4, 16'd3000);

        // R8: clear with a cause held
        enable_in = 0; cycle();
        chk("R10", "drive_en", {15'b0, drive_en}, 16'd0);
        wr(4'd8, 16'd1);
        reg_addr = 4'd8; #0.2; chk("R8", "flag", reg_rdata, 16'h1);
        cycle();
        reg_addr = 4'd8; #0.2; chk("R8", "flag self", reg_rdata, 16'h0);
        reg_addr = 4'd5; #0.2; chk("R8", "empty", reg_rdata, 16'h0);
        cycle();
        reg_addr = 4'd5; #0.2; chk("R8", "relatch", reg_rdata, 16'h0002);
        enable_in = 1; wr(4'd8, 16'd1); cycle(); cycle();
        chk_all("R8");

        // R9: undervoltage mask
        bus_v = 16'd1000; cycle();
        reg_addr = 4'd5; #0.2; chk("R5", "uv", reg_rdata, 16'h0100);
        chk("R9", "masked off", {15'b0, fault_out}, 16'd0);
        wr(4'd6, 16'h0000);
        reg_addr = 4'd6; #0.2; chk("R9", "mask", reg_rdata, 16'hFEFF);
        chk("R9", "fault_out", {15'b0, fault_out}, 16'd1);
        chk("R9", "drive_en", {15'b0, drive_en}, 16'd1);
        temp_c = 16'd8501; cycle();
        chk("R10", "otemp", {15'b0, fault_out}, 16'd0);
        temp_c = 16'd2500; bus_v = 16'd30000; wr(4'd8, 16'd1); cycle(); cycle();
        chk_all("R9");

        // R5: random traffic with occasional writes and clears
        for (int i = 0; i < 3000; i++) begin
            bus_v   = 16'd28000 + 16'($urandom % 14000);
            cur_u   = 16'($urandom % 4200);
            cur_v   = 16'($urandom % 4200);
            cur_w   = 16'($urandom % 4200);
            temp_c  = 16'($urandom % 9000);
            wdog_to = ($urandom % 40) == 0;
            enable_in = ($urandom % 30) != 0;
            hs_ocp  = ($urandom % 40) == 0;
            module_flt = ($urandom % 40) == 0;
            ser_ovr = ($urandom % 40) == 0;
            ser_frm = ($urandom % 40) == 0;
            ilim_in = $urandom % 2;
            case ($urandom % 12)
                0: wr(4'd0, 16'd30000 + 16'($urandom % 12000));
                1: wr(4'd1, 16'd30000 + 16'($urandom % 12000));
                2: wr(4'd2, 16'($urandom % 32000));
                3: wr(4'd3, 16'd30000 + 16'($urandom % 12000));
                4: wr(4'd4, 16'd1000 + 16'($urandom % 5000));
                5: wr(4'd6, 16'($urandom));
                6: wr(4'd7, 16'd0);
                7, 8: wr(4'd8, 16'd1);
                9: wr(4'd5, 16'($urandom));
                default: cycle();
            endcase
            chk_all("R5");
        end

        done = 1;
        summary();
        $finish;
    end
endmodule